// File: doc/BRIEF.md
# Transfer Descriptor Commit Queue

This block is the write side of a scatter-gather transfer engine. A host writes one transfer descriptor as eight 32-bit words through a simple memory-mapped write port. The first seven words only load staging registers. The descriptor enters an internal queue only when the eighth word, the control word, is written with its commit bit set. On that write the block takes the seven staged words and the control value from the same bus write, and enqueues all 256 bits in one cycle. A half-written descriptor can therefore never reach the engine.

The queue gives the host empty and full flags and a 16-bit occupancy count, so software can hold off while the queue is full. A commit that arrives while the queue is full is dropped and sets a sticky overflow flag. Toward the transfer engine the block offers the oldest descriptor on a valid/ready handshake. It also decodes the burst and sequence fields of that descriptor, so the engine does not have to.

Top module: `dstage_commit_port`

## Requirements
- R1: After reset `fifo_empty` is 1, and `fifo_full`, `fill_level`, `overflow` and `dsc_valid` are all 0.
- R2: The word index is `wr_addr[4:2]`, and `wr_addr[1:0]` is ignored. A write to any index from 0 to 6 (byte offsets 0x00 to 0x18) only loads that staging word. It never changes `fill_level`.
- R3: A write to index 7 (offset 0x1C) with `wr_data[31]` clear enqueues nothing.
- R4: A write to index 7 with `wr_data[31]` set, while `fifo_full` is 0, enqueues one descriptor. In that descriptor, staged word i sits at bits 32*i+31:32*i for i from 0 to 6, and the written control value sits at bits 255:224. `fill_level` rises by one at the same clock edge.
- R5: `dsc_valid` rises on the second clock edge after a commit into an empty queue. Descriptors leave in commit order, one for each cycle in which `dsc_valid` and `dsc_ready` are both high. While `dsc_ready` is low, `dsc_data` holds steady.
- R6: `fifo_full` is 1 exactly when `fill_level` equals DEPTH, and `fifo_empty` is 1 exactly when `fill_level` is 0. Both flags are registered and update at the same edge as the count.
- R7: A commit write while `fifo_full` is 1 is dropped: `fill_level` stays unchanged and `overflow` becomes 1. `overflow` then stays 1 until reset. The staging words are left unchanged by the dropped write.
- R8: Staging words persist across commits. A later commit that rewrites only the control word re-sends the previously staged words.
- R9: The head descriptor's word 3 is decoded as follows. Bits 31:24 give `dsc_wr_burst`, bits 23:16 give `dsc_rd_burst`, and bits 15:0 give `dsc_seq`. A burst field of 0 is reported as MAX_BURST.
- R10: An accepted commit and a pop in the same cycle leave `fill_level` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the descriptor window |
| wr_addr | input | 5 | Byte address within the 32-byte descriptor window |
| wr_data | input | 32 | Write data |
| fifo_empty | output | 1 | Queue holds no descriptor |
| fifo_full | output | 1 | Queue holds DEPTH descriptors |
| fill_level | output | 16 | Number of queued descriptors |
| overflow | output | 1 | Sticky: a commit was dropped while full |
| dsc_valid | output | 1 | Head descriptor available |
| dsc_ready | input | 1 | Engine accepts the head descriptor |
| dsc_data | output | 256 | Head descriptor, word i at bits 32*i+31:32*i |
| dsc_rd_burst | output | 8 | Effective read burst of the head descriptor |
| dsc_wr_burst | output | 8 | Effective write burst of the head descriptor |
| dsc_seq | output | 16 | Sequence number of the head descriptor |

## Verification
The bench first writes staging words and a control word with the commit bit clear, which shows that nothing reaches the queue before a real commit. It then commits single descriptors with zero and nonzero burst fields, which separates the maximum-burst substitution from a plain field pass-through. It fills the queue, issues one more commit and then drains, which shows the drop, the sticky flag, first-in first-out order and that the staging registers survive the dropped write. Finally it overlaps a commit with a pop in one cycle, which tells apart a correct net-zero count update from one that loses or doubles an entry.

// File: rtl/dstage_pkg.sv
package dstage_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 8;
  localparam int DESC_W    = WORD_W * NUM_WORDS;
  localparam int IDX_W     = $clog2(NUM_WORDS);
  localparam int ADDR_W    = IDX_W + 2;
  localparam int CTRL_IDX  = NUM_WORDS - 1;
  localparam int GO_BIT    = 31;
  localparam int BURST_IDX = 3;
  localparam int LEVEL_W   = 16;

  typedef logic [DESC_W-1:0] desc_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/dstage_stage.sv
module dstage_stage
  import dstage_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  word_t             wr_data_i,
  input  logic              full_i,
  output logic              push_o,
  output desc_t             push_desc_o,
  output logic              ovf_o
);
  localparam int STAGED = NUM_WORDS - 1;

  logic [IDX_W-1:0] idx;
  logic             is_ctrl, commit, drop;
  logic             unused_lo;
  word_t            stage_q [STAGED];

  assign idx       = wr_addr_i[ADDR_W-1:2];
  assign unused_lo = ^wr_addr_i[1:0];
  assign is_ctrl   = (idx == IDX_W'(CTRL_IDX));
  assign commit    = wr_en_i && is_ctrl && wr_data_i[GO_BIT];
  assign drop      = commit && full_i;
  assign push_o    = commit && !full_i;

  for (genvar g = 0; g < STAGED; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[g] <= '0;
      end else if (wr_en_i && (idx == IDX_W'(g))) begin
        stage_q[g] <= wr_data_i;
      end
    end
  end

  always_comb begin
    push_desc_o = '0;
    for (int i = 0; i < STAGED; i++) begin
      push_desc_o[i*WORD_W +: WORD_W] = stage_q[i];
    end
    push_desc_o[CTRL_IDX*WORD_W +: WORD_W] = wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_o <= 1'b0;
    end else if (drop) begin
      ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dstage_ram.sv
module dstage_ram #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 256,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             re_i,
  input  logic [PTR_W-1:0] raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (re_i) begin
      rdata_o <= mem[raddr_i];
    end
  end
endmodule

// File: rtl/dstage_fifo_ctrl.sv
module dstage_fifo_ctrl #(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic             ready_i,
  output logic             we_o,
  output logic [PTR_W-1:0] waddr_o,
  output logic             re_o,
  output logic [PTR_W-1:0] raddr_o,
  output logic             valid_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [LVL_W-1:0] mem_cnt_q, mem_cnt_d, lvl_q, lvl_d;
  logic             valid_q, full_q, empty_q;
  logic             pop, load;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign pop  = valid_q && ready_i;
  assign load = (mem_cnt_q != '0) && (!valid_q || pop);

  always_comb begin
    mem_cnt_d = mem_cnt_q + LVL_W'(push_i) - LVL_W'(load);
    lvl_d     = lvl_q + LVL_W'(push_i) - LVL_W'(pop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q    <= '0;
      rptr_q    <= '0;
      mem_cnt_q <= '0;
      lvl_q     <= '0;
      valid_q   <= 1'b0;
      full_q    <= 1'b0;
      empty_q   <= 1'b1;
    end else begin
      if (push_i) wptr_q <= bump(wptr_q);
      if (load)   rptr_q <= bump(rptr_q);
      mem_cnt_q <= mem_cnt_d;
      lvl_q     <= lvl_d;
      valid_q   <= load || (valid_q && !pop);
      full_q    <= (lvl_d == LVL_W'(DEPTH));
      empty_q   <= (lvl_d == '0);
    end
  end

  assign we_o    = push_i;
  assign waddr_o = wptr_q;
  assign re_o    = load;
  assign raddr_o = rptr_q;
  assign valid_o = valid_q;
  assign level_o = lvl_q;
  assign full_o  = full_q;
  assign empty_o = empty_q;
endmodule

// File: rtl/dstage_commit_port.sv
module dstage_commit_port
  import dstage_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int MAX_BURST = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [WORD_W-1:0]   wr_data,
  output logic                fifo_empty,
  output logic                fifo_full,
  output logic [LEVEL_W-1:0]  fill_level,
  output logic                overflow,
  output logic                dsc_valid,
  input  logic                dsc_ready,
  output logic [DESC_W-1:0]   dsc_data,
  output logic [7:0]          dsc_rd_burst,
  output logic [7:0]          dsc_wr_burst,
  output logic [15:0]         dsc_seq
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [7:0] MAX_B = 8'(MAX_BURST);
  localparam int BURST_LSB = BURST_IDX * WORD_W;

  logic             push, full_w;
  desc_t            push_desc;
  logic             we, re;
  logic [PTR_W-1:0] waddr, raddr;
  logic [LVL_W-1:0] lvl;

  dstage_stage stage_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .full_i      (full_w),
    .push_o      (push),
    .push_desc_o (push_desc),
    .ovf_o       (overflow)
  );

  dstage_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .push_i  (push),
    .ready_i (dsc_ready),
    .we_o    (we),
    .waddr_o (waddr),
    .re_o    (re),
    .raddr_o (raddr),
    .valid_o (dsc_valid),
    .level_o (lvl),
    .full_o  (full_w),
    .empty_o (fifo_empty)
  );

  dstage_ram #(.DEPTH(DEPTH), .WIDTH(DESC_W)) ram_i (
    .clk     (clk),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (push_desc),
    .re_i    (re),
    .raddr_i (raddr),
    .rdata_o (dsc_data)
  );

  assign fifo_full  = full_w;
  assign fill_level = LEVEL_W'(lvl);

  logic [7:0] raw_burst [2];
  logic [7:0] eff_burst [2];
  assign raw_burst[0] = dsc_data[BURST_LSB + 16 +: 8];
  assign raw_burst[1] = dsc_data[BURST_LSB + 24 +: 8];

  for (genvar b = 0; b < 2; b++) begin : g_burst
    assign eff_burst[b] = (raw_burst[b] == 8'd0) ? MAX_B : raw_burst[b];
  end

  assign dsc_rd_burst = eff_burst[0];
  assign dsc_wr_burst = eff_burst[1];
  assign dsc_seq      = dsc_data[BURST_LSB +: 16];
endmodule

// File: rtl/dstage_commit_port_chk.sv
module dstage_commit_port_chk #(
  parameter int DEPTH = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic [4:0]   wr_addr,
  input logic [31:0]  wr_data,
  input logic         fifo_empty,
  input logic         fifo_full,
  input logic [15:0]  fill_level,
  input logic         overflow,
  input logic         dsc_valid,
  input logic         dsc_ready,
  input logic [255:0] dsc_data
);
  logic is_ctrl, pop;
  assign is_ctrl = wr_en && (wr_addr[4:2] == 3'd7);
  assign pop     = dsc_valid && dsc_ready;

  AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !is_ctrl && !pop) |=> (fill_level == $past(fill_level))); // R2
  AST_NO_GO_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
    (is_ctrl && !wr_data[31] && !pop) |=> (fill_level == $past(fill_level))); // R3
  AST_COMMIT_ADDS: assert property (@(posedge clk) disable iff (rst)
    (is_ctrl && wr_data[31] && !fifo_full && !pop) |=> (fill_level == $past(fill_level) + 16'd1)); // R4
  AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (rst)
    (dsc_valid && !dsc_ready) |=> (dsc_valid && $stable(dsc_data))); // R5
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(fifo_full && fifo_empty)); // R6
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    fill_level <= 16'(DEPTH)); // R6
  AST_EMPTY_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    fifo_empty |-> !dsc_valid); // R6
  AST_NO_OVERFLOW_PUSH: assert property (@(posedge clk) disable iff (rst)
    (is_ctrl && wr_data[31] && fifo_full && !pop) |=> (overflow && fill_level == $past(fill_level))); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R7
  AST_PUSH_POP_NET: assert property (@(posedge clk) disable iff (rst)
    (is_ctrl && wr_data[31] && !fifo_full && pop) |=> (fill_level == $past(fill_level))); // R10
endmodule

bind dstage_commit_port dstage_commit_port_chk #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .fifo_empty (fifo_empty),
  .fifo_full  (fifo_full),
  .fill_level (fill_level),
  .overflow   (overflow),
  .dsc_valid  (dsc_valid),
  .dsc_ready  (dsc_ready),
  .dsc_data   (dsc_data)
);

// File: tb/dstage_commit_port_tb_top.sv
module dstage_commit_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int MAX_BURST  = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [4:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         dsc_ready = 1'b0;
  logic         fifo_empty, fifo_full, overflow, dsc_valid;
  logic [15:0]  fill_level, dsc_seq;
  logic [255:0] dsc_data;
  logic [7:0]   dsc_rd_burst, dsc_wr_burst;

  always #(CLK_PERIOD/2) clk = ~clk;

  dstage_commit_port #(.DEPTH(DEPTH), .MAX_BURST(MAX_BURST)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fill_level(fill_level),
    .overflow(overflow), .dsc_valid(dsc_valid), .dsc_ready(dsc_ready),
    .dsc_data(dsc_data), .dsc_rd_burst(dsc_rd_burst), .dsc_wr_burst(dsc_wr_burst),
    .dsc_seq(dsc_seq)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0]  stg [7];
  logic [255:0] expq [$];

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] mk(input logic [31:0] ctrl);
    logic [255:0] r;
    for (int i = 0; i < 7; i++) r[i*32 +: 32] = stg[i];
    r[255:224] = ctrl;
    return r;
  endfunction

  task automatic wr(input int off, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = off[4:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (off / 4 < 7) stg[off/4] = d;
    else if (d[31] && expq.size() < DEPTH) expq.push_back(mk(d));
  endtask

  task automatic pop_one(input string req);
    @(negedge clk);
    chk({req, " valid"}, 256'(dsc_valid), 256'(1));
    chk({req, " order/data"}, dsc_data, expq[0]);
    dsc_ready = 1'b1;
    @(negedge clk);
    dsc_ready = 1'b0;
    void'(expq.pop_front());
  endtask

  task automatic t_reset();
    chk("R1 empty", 256'(fifo_empty), 256'(1));
    chk("R1 full", 256'(fifo_full), 256'(0));
    chk("R1 level", 256'(fill_level), 256'(0));
    chk("R1 valid", 256'(dsc_valid), 256'(0));
    chk("R1 overflow", 256'(overflow), 256'(0));
  endtask

  task automatic t_stage_only();
    for (int i = 0; i < 7; i++) wr(i*4 + (i % 4), 32'h1000_0000 + i);
    chk("R2 level after staging", 256'(fill_level), 256'(0));
    wr(8'h1C, 32'h0000_1234);
    @(negedge clk);
    chk("R3 level after ctrl without go", 256'(fill_level), 256'(0));
    chk("R3 valid after ctrl without go", 256'(dsc_valid), 256'(0));
    chk("R3 empty after ctrl without go", 256'(fifo_empty), 256'(1));
  endtask

  task automatic t_single();
    wr(8'h0C, 32'h0005_BEEF);
    wr(8'h1C, 32'h8000_2301);
    chk("R4 level after commit", 256'(fill_level), 256'(1));
    chk("R4 empty after commit", 256'(fifo_empty), 256'(0));
    chk("R5 valid not yet on first edge", 256'(dsc_valid), 256'(0));
    @(negedge clk);
    chk("R4 descriptor layout", dsc_data, expq[0]);
    chk("R9 zero wr burst -> max", 256'(dsc_wr_burst), 256'(MAX_BURST));
    chk("R9 rd burst", 256'(dsc_rd_burst), 256'(5));
    chk("R9 sequence", 256'(dsc_seq), 256'(16'hBEEF));
    pop_one("R5 single");
    chk("R5 empty after pop", 256'(fifo_empty), 256'(1));
    chk("R5 level after pop", 256'(fill_level), 256'(0));
  endtask

  task automatic t_fill();
    wr(8'h0C, 32'h0A00_0002);
    for (int k = 0; k < DEPTH; k++) begin
      wr(8'h00, 32'hA000_0000 + k);
      wr(8'h1C, 32'h8000_0000 + k);
    end
    chk("R6 full at depth", 256'(fifo_full), 256'(1));
    chk("R6 level at depth", 256'(fill_level), 256'(DEPTH));
    chk("R6 not empty", 256'(fifo_empty), 256'(0));
    chk("R9 nonzero wr burst", 256'(dsc_wr_burst), 256'(8'h0A));
    chk("R9 zero rd burst -> max", 256'(dsc_rd_burst), 256'(MAX_BURST));
    chk("R7 no overflow yet", 256'(overflow), 256'(0));
    wr(8'h1C, 32'h8000_00FF);
    chk("R7 overflow set", 256'(overflow), 256'(1));
    chk("R7 level unchanged", 256'(fill_level), 256'(DEPTH));
    for (int k = 0; k < DEPTH; k++) pop_one("R5 fifo order");
    chk("R6 empty after drain", 256'(fifo_empty), 256'(1));
    chk("R6 not full after drain", 256'(fifo_full), 256'(0));
    chk("R7 overflow sticky", 256'(overflow), 256'(1));
    wr(8'h1C, 32'h8000_0055);
    pop_one("R8 R7 staging kept");
  endtask

  task automatic t_simul();
    wr(8'h04, 32'h5555_0001);
    wr(8'h1C, 32'h8000_0A0A);
    wr(8'h1C, 32'h8000_0B0B);
    @(negedge clk);
    chk("R10 head before overlap", dsc_data, expq[0]);
    dsc_ready = 1'b1; wr_en = 1'b1; wr_addr = 5'h1C; wr_data = 32'h8000_0C0C;
    @(negedge clk);
    dsc_ready = 1'b0; wr_en = 1'b0;
    void'(expq.pop_front());
    expq.push_back(mk(32'h8000_0C0C));
    chk("R10 level unchanged", 256'(fill_level), 256'(2));
    pop_one("R10 after overlap");
    pop_one("R10 after overlap");
    chk("R10 empty at end", 256'(fifo_empty), 256'(1));
  endtask

  initial begin
    for (int i = 0; i < 7; i++) stg[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_stage_only();
    t_single();
    t_fill();
    t_simul();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule